// File: doc/BRIEF.md
# Dual-Gain Sample Combiner

The block joins two 8-bit conversions of one analog signal into a single 12-bit sample. One conversion is taken at normal gain. The other is taken at a gain sixteen times higher, which is 24 dB more. The four low bits of the normal-gain byte and the four high bits of the high-gain byte therefore carry the same weight. The combined word takes its top nibble from the normal-gain byte and its bottom nibble from the high-gain byte.

Two ways of forming the middle nibble can be chosen per sample. In the concatenating mode the high-gain byte is used whole. In the reconciling mode the two overlapping nibbles are averaged. Before averaging, the block detects a pair in which one nibble has wrapped past the other end of its range and corrects the sum by one nibble span. A corrected middle value can leave the range 0..15. When it does, it carries into or borrows from the top nibble, and the final value is clamped to the 12-bit range.

Each accepted sample appears on the output one clock later. The output holds its value while no sample is offered.

Top module: `dual_gain_combiner`

## Requirements
- R1: With `avg_en` low, an accepted sample produces `out_sample` = {`lo_sample[7:4]`, `hi_sample[7:0]`}.
- R2: With `avg_en` high and no wrap condition, let L = `lo_sample[3:0]` and H = `hi_sample[7:4]`. The middle value is floor((L+H)/2), and `out_sample` = `lo_sample[7:4]`*256 + middle*16 + `hi_sample[3:0]`. A pair such as L=11 with H=11, or L=3 with H=11, is not a wrap.
- R3: Upward wrap is L ≥ 12 together with H < 4. In that case the middle value is (L+H+16)/2.
- R4: Downward wrap is L < 4 together with H ≥ 12. In that case the middle value is (L+H−16)/2, and the halving truncates toward zero, so −1 gives 0 and −3 gives −1.
- R5: A middle value of 16 or 17 carries into the top nibble, which is then one more than `lo_sample[7:4]`.
- R6: A negative middle value borrows from the top nibble.
- R7: In reconciling mode the result saturates: any value above 4095 gives 4095 (0xFFF), and any value below 0 gives 0.
- R8: `out_valid` equals `in_valid` delayed by one clock, and `out_sample` carries the result of the sample accepted on the previous clock.
- R9: While `in_valid` is low, `out_sample` keeps its value, and the data and mode inputs have no effect.
- R10: While reset is asserted, `out_valid` and `out_sample` are 0. Reset takes effect at once and is released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample pair is offered this cycle |
| lo_sample | input | 8 | Normal-gain conversion |
| hi_sample | input | 8 | Conversion at 16x gain |
| avg_en | input | 1 | 1 selects the reconciling mode, 0 selects concatenation |
| out_valid | output | 1 | `out_sample` holds a new result |
| out_sample | output | 12 | Combined sample |

## Verification
A fault in the wrap detection or in the halving shows up only for nibble pairs near the ends of their range, so the stimulus deliberately covers the threshold pairs and both truncation signs. Each such fault appears on `out_sample` one clock after the sample is offered. A fault in the carry or saturation path changes the top nibble or the clamp value on that same next clock. The top nibble can move by at most one step from the normal-gain nibble, so a larger difference exposes the fault immediately. A register that loads when it should hold shows up on the first idle cycle, as a changed `out_sample` while `out_valid` is low.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  // Mode encoding as seen on the avg_en input.
  typedef enum logic {
    MODE_CONCAT = 1'b0,
    MODE_AVG    = 1'b1
  } dgc_mode_e;
endpackage

// File: rtl/dgc_rst_sync.sv
module dgc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/dgc_mid_reconcile.sv
module dgc_mid_reconcile #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0]        ovl_lo,
  input  logic [NIB_W-1:0]        ovl_hi,
  output logic signed [NIB_W+2:0] mid
);
  localparam int SUM_W    = NIB_W + 3;
  localparam int SPAN     = 1 << NIB_W;
  localparam int TH_UPPER = (3 * SPAN) / 4;
  localparam int TH_LOWER = SPAN / 4;
  localparam logic signed [SUM_W-1:0] SPAN_S = SUM_W'(SPAN);
  localparam logic signed [SUM_W-1:0] ONE_S  = SUM_W'(1);

  logic                    wrap_up;
  logic                    wrap_dn;
  logic signed [SUM_W-1:0] lo_s;
  logic signed [SUM_W-1:0] hi_s;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] sum_adj;

  always_comb begin
    wrap_up = (ovl_lo >= NIB_W'(TH_UPPER)) && (ovl_hi <  NIB_W'(TH_LOWER));
    wrap_dn = (ovl_lo <  NIB_W'(TH_LOWER)) && (ovl_hi >= NIB_W'(TH_UPPER));
    lo_s    = $signed({3'b000, ovl_lo});
    hi_s    = $signed({3'b000, ovl_hi});
    sum     = lo_s + hi_s;
    if (wrap_up) begin
      sum = sum + SPAN_S;
    end else if (wrap_dn) begin
      sum = sum - SPAN_S;
    end
    // Halve with truncation toward zero.
    sum_adj = sum[SUM_W-1] ? (sum + ONE_S) : sum;
    mid     = sum_adj >>> 1;
  end
endmodule

// File: rtl/dgc_assemble.sv
module dgc_assemble #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0]        top_nib,
  input  logic signed [NIB_W+2:0] mid,
  input  logic [NIB_W-1:0]        bot_nib,
  output logic [3*NIB_W-1:0]      result
);
  localparam int OUT_W  = 3 * NIB_W;
  localparam int SUM_W  = NIB_W + 3;
  localparam int FULL_W = OUT_W + 2;
  localparam logic signed [FULL_W-1:0] OUT_MAX = FULL_W'((1 << OUT_W) - 1);

  logic signed [FULL_W-1:0] top_s;
  logic signed [FULL_W-1:0] mid_s;
  logic signed [FULL_W-1:0] bot_s;
  logic signed [FULL_W-1:0] full;

  always_comb begin
    top_s = $signed({2'b00, top_nib, {(2*NIB_W){1'b0}}});
    mid_s = $signed({{(FULL_W-SUM_W){mid[SUM_W-1]}}, mid}) <<< NIB_W;
    bot_s = $signed({{(FULL_W-NIB_W){1'b0}}, bot_nib});
    full  = top_s + mid_s + bot_s;
    if (full[FULL_W-1]) begin
      result = '0;
    end else if (full > OUT_MAX) begin
      result = '1;
    end else begin
      result = full[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/dual_gain_combiner.sv
module dual_gain_combiner #(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2*NIB_W-1:0]   lo_sample,
  input  logic [2*NIB_W-1:0]   hi_sample,
  input  logic                 avg_en,
  output logic                 out_valid,
  output logic [3*NIB_W-1:0]   out_sample
);
  import dgc_pkg::*;

  localparam int SAMPLE_W = 2 * NIB_W;
  localparam int OUT_W    = 3 * NIB_W;
  localparam int SUM_W    = NIB_W + 3;

  logic                    rst_sync_n;
  logic signed [SUM_W-1:0] mid;
  logic [OUT_W-1:0]        avg_val;
  logic [OUT_W-1:0]        cat_val;
  logic [OUT_W-1:0]        out_d;
  logic [OUT_W-1:0]        out_q;
  logic                    vld_d;
  logic                    vld_q;
  dgc_mode_e               mode;

  dgc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dgc_mid_reconcile #(.NIB_W(NIB_W)) u_mid (
    .ovl_lo (lo_sample[NIB_W-1:0]),
    .ovl_hi (hi_sample[SAMPLE_W-1:NIB_W]),
    .mid    (mid)
  );

  dgc_assemble #(.NIB_W(NIB_W)) u_asm (
    .top_nib (lo_sample[SAMPLE_W-1:NIB_W]),
    .mid     (mid),
    .bot_nib (hi_sample[NIB_W-1:0]),
    .result  (avg_val)
  );

  assign cat_val = {lo_sample[SAMPLE_W-1:NIB_W], hi_sample};
  assign mode    = dgc_mode_e'(avg_en);

  // Next-state logic: the output register loads only on an accepted sample.
  always_comb begin
    vld_d = in_valid;
    out_d = out_q;
    if (in_valid) begin
      out_d = (mode == MODE_AVG) ? avg_val : cat_val;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      out_q <= '0;
    end else begin
      vld_q <= vld_d;
      out_q <= out_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_sample = out_q;
endmodule

// File: rtl/dgc_checker.sv
module dgc_checker #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [2*NIB_W-1:0] lo_sample,
  input logic [2*NIB_W-1:0] hi_sample,
  input logic               avg_en,
  input logic               out_valid,
  input logic [3*NIB_W-1:0] out_sample
);
  localparam int SAMPLE_W = 2 * NIB_W;
  localparam int OUT_W    = 3 * NIB_W;

  logic             avg_q;
  logic [NIB_W-1:0] top_q;
  logic [NIB_W-1:0] bot_q;
  logic signed [NIB_W+1:0] top_diff;
  logic             clamped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q <= 1'b0;
      top_q <= '0;
      bot_q <= '0;
    end else begin
      avg_q <= in_valid && avg_en;
      top_q <= lo_sample[SAMPLE_W-1:NIB_W];
      bot_q <= hi_sample[NIB_W-1:0];
    end
  end

  assign top_diff = $signed({2'b00, out_sample[OUT_W-1:2*NIB_W]}) - $signed({2'b00, top_q});
  assign clamped  = (out_sample == '0) || (out_sample == '1);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample)); // R9
  AST_CONCAT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !avg_en) |=>
      (out_sample == {$past(lo_sample[SAMPLE_W-1:NIB_W]), $past(hi_sample)})); // R1
  AST_BOTTOM_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    avg_q |-> (clamped || out_sample[NIB_W-1:0] == bot_q)); // R2
  AST_TOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    avg_q |-> (clamped || (top_diff >= -1 && top_diff <= 1))); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_sample == '0)); // R10
endmodule

bind dual_gain_combiner dgc_checker #(.NIB_W(NIB_W)) u_dgc_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .lo_sample  (lo_sample),
  .hi_sample  (hi_sample),
  .avg_en     (avg_en),
  .out_valid  (out_valid),
  .out_sample (out_sample)
);

// File: tb/test_dual_gain_combiner.sv
`timescale 1ns/1ps
module test_dual_gain_combiner;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  lo_sample;
  logic [7:0]  hi_sample;
  logic        avg_en;
  logic        out_valid;
  logic [11:0] out_sample;

  int n_checks;
  int n_fails;
  int cycles;
  bit done;

  localparam int NVEC = 18;
  // {avg_en, lo_sample, hi_sample, expected out_sample}
  localparam bit [28:0] VECS [NVEC] = '{
    {1'b0, 8'hA5, 8'h3C, 12'hA3C},  // R1
    {1'b0, 8'h0F, 8'hFF, 12'h0FF},  // R1
    {1'b1, 8'h37, 8'h89, 12'h379},  // R2 7+8 -> 7
    {1'b1, 8'h24, 8'h4B, 12'h24B},  // R2 4,4
    {1'b1, 8'h0B, 8'hB4, 12'h0B4},  // R2 11,11 no wrap
    {1'b1, 8'h33, 8'hB1, 12'h371},  // R2 3,11 no wrap
    {1'b1, 8'h5D, 8'h2A, 12'h5FA},  // R3 13,2 -> 15
    {1'b1, 8'h1C, 8'h07, 12'h1E7},  // R3 12,0 -> 14
    {1'b1, 8'h6E, 8'h35, 12'h705},  // R5 14,3 -> 16
    {1'b1, 8'h4F, 8'h3F, 12'h51F},  // R5 15,3 -> 17
    {1'b1, 8'h82, 8'hD6, 12'h806},  // R4 -1 -> 0
    {1'b1, 8'h71, 8'hE0, 12'h700},  // R4 -1 -> 0
    {1'b1, 8'hA3, 8'hF2, 12'hA12},  // R4 2 -> 1
    {1'b1, 8'h90, 8'hC3, 12'h8E3},  // R6 -4 -> -2
    {1'b1, 8'h11, 8'hC9, 12'h0F9},  // R6 -3 -> -1
    {1'b1, 8'hFF, 8'h28, 12'hFFF},  // R7 4104 clamps high
    {1'b1, 8'h01, 8'hC9, 12'h000},  // R7 -7 clamps low
    {1'b0, 8'hFF, 8'hC9, 12'hFC9}   // R1
  };
  localparam int VREQ [NVEC] = '{1,1,2,2,2,2,3,3,5,5,4,4,4,6,6,7,7,1};

  dual_gain_combiner i_dual_gain_combiner (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .lo_sample  (lo_sample),
    .hi_sample  (hi_sample),
    .avg_en     (avg_en),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    lo_sample = 8'h00;
    hi_sample = 8'h00;
    avg_en    = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid in reset", {11'd0, out_valid}, 12'd0);
    check("R10 data in reset", out_sample, 12'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 valid after release", {11'd0, out_valid}, 12'd0);

    // Table walk, back-to-back samples
    for (int i = 0; i < NVEC; i++) begin
      {avg_en, lo_sample, hi_sample} = VECS[i][28:12];
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VREQ[i], i), out_sample, VECS[i][11:0]);
      check($sformatf("R8 valid vector %0d", i), {11'd0, out_valid}, 12'd1);
    end

    // R9: idle cycles with changing inputs leave the output alone
    in_valid  = 1'b0;
    avg_en    = 1'b1;
    lo_sample = 8'h37;
    hi_sample = 8'h89;
    @(negedge clk);
    check("R8 valid drops", {11'd0, out_valid}, 12'd0);
    check("R9 hold idle 1", out_sample, 12'hFC9);
    avg_en    = 1'b0;
    lo_sample = 8'h00;
    hi_sample = 8'h00;
    @(negedge clk);
    check("R9 hold idle 2", out_sample, 12'hFC9);

    // R8: single pulse appears exactly one cycle later
    lo_sample = 8'h5D;
    hi_sample = 8'h2A;
    avg_en    = 1'b1;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 pulse data", out_sample, 12'h5FA);
    check("R8 pulse valid", {11'd0, out_valid}, 12'd1);
    @(negedge clk);
    check("R8 pulse ends", {11'd0, out_valid}, 12'd0);
    check("R9 hold after pulse", out_sample, 12'h5FA);

    // R10: asynchronous reset mid-stream
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check("R10 async clear data", out_sample, 12'h000);
    check("R10 async clear valid", {11'd0, out_valid}, 12'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 stays clear", out_sample, 12'h000);

    done = 1'b1;
    finish_run();
  end
endmodule